// File: doc/BRIEF.md
# Queued SPI Master with Per-Entry Command Words

This block is an SPI bus master that works through a short list of byte transfers on its own once software has set it up. Software fills three small per-entry stores through a 32-bit register port: an outgoing byte, a command word, and a slot for the incoming byte. It then names the first and last entry of the run and sets the enable bit. The sequencer visits each entry in index order, wrapping past the top index. For each entry it drives the chip-select pattern taken from that entry's command word and shifts one byte out on MOSI while it captures one byte from MISO. At the end it raises a done flag and a level interrupt.

The command word decides, entry by entry, whether chip select stays asserted into the next entry. Two controls decide whether it stays asserted past the last entry of a run: a continue-after-run mode bit in the control register and a separate hold (write-lock) register. With either one set, a long bus transaction can be split into several runs of at most sixteen bytes each without a chip-select break. The bus uses SPI mode 0, MSB first, eight bits per entry. The SCLK half period is set in system clocks by a divider register.

Top module: `sq_spi_master`

## Requirements
- R1: After reset all four chip-select outputs are high (4'hF), SCLK and the interrupt are low, and the control (0x218) and status (0x220) registers read 0.
- R2: A run sends the transmit bytes of entries start (0x210) through end (0x214) in index order, MSB first. SCLK idles low and MOSI is stable at every SCLK rising edge. Each SCLK half period lasts the number of system clocks held in the divider register (0x200). A transmit byte is written at 0x240 + 8·i.
- R3: The byte captured from MISO for entry i reads back in bits 7:0 at 0x2C0 + 8·i + 4 (the odd slot). The even slot 0x2C0 + 8·i reads 0.
- R4: Writing control with bit 6 set starts a run. Bit 6 reads 1 from the next cycle until the run ends, and then reads 0 without any write.
- R5: When the last entry finishes, status bit 0 and the interrupt output go high. A status write with bit 0 clear lowers both.
- R6: While an entry shifts, cs_n equals bits 3:0 of that entry's command word (0x340 + 4·i). The value 4'hF selects no device.
- R7: Command bit 7 set on an entry that is not the last keeps cs_n asserted into the next entry with no break. Bit 7 clear raises cs_n to 4'hF for at least one full SCLK period (two half periods) before the next entry.
- R8: If the last entry has bit 7 set and either control bit 7 or the hold register (0x380, bit 0) is set, cs_n stays asserted after the run, and the next run continues the same frame. If both controls are cleared while idle, cs_n is released.
- R9: If the last entry has bit 7 set but neither control bit 7 nor the hold register is set, cs_n is released when the run ends.
- R10: The current-entry register (0x224) gives the index being processed. After a run it holds the end index.
- R11: When the end index is below the start index, the run wraps from entry 15 to entry 0.
- R12: Command bit 4 delays the first SCLK rising edge after chip-select assertion by exactly one extra SCLK half period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| sclk | output | 1 | SPI clock, mode 0 |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |
| irq | output | 1 | Completion interrupt, high while status bit 0 is set |

## Verification
A sequencer that stepped the pointer wrongly, or that latched the wrong command word, shows up at the SPI pins within a single byte time. The byte stream, or the chip-select value seen at each SCLK rise, no longer matches the scoreboard's next expected item. A wrong keep/release decision shows up as a changed frame count, a chip-select gap shorter than two half periods, or a select left low after the run. These are all visible on the cycle after the last byte. Capture or slot errors show only when the receive RAM is read back, right after the done interrupt.

// File: rtl/sq_pkg.sv
// Package: shared state type, register offsets and field positions for the
// queued SPI master. Assumes a 12-bit byte address space.
package sq_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_LOAD  = 3'd1,
        SQ_SETUP = 3'd2,
        SQ_SHIFT = 3'd3,
        SQ_GAP   = 3'd4
    } sq_state_t;

    localparam int OFF_DIV    = 'h200;
    localparam int OFF_NEWQ   = 'h210;
    localparam int OFF_ENDQ   = 'h214;
    localparam int OFF_CTRL   = 'h218;
    localparam int OFF_STATUS = 'h220;
    localparam int OFF_CURQ   = 'h224;
    localparam int OFF_TXRAM  = 'h240;
    localparam int OFF_RXRAM  = 'h2C0;
    localparam int OFF_CMDRAM = 'h340;
    localparam int OFF_HOLD   = 'h380;

    localparam int CMD_DLY  = 4;
    localparam int CMD_KEEP = 7;
    localparam int CTL_EN   = 6;
    localparam int CTL_CONT = 7;
endpackage

// File: rtl/sq_shift.sv
// Module: sq_shift
// Byte shifter for SPI mode 0. It moves one byte per start pulse, MSB first.
// SCLK idles low. MISO is sampled on the rising edge and MOSI changes on the
// falling edge. Assumes div_i >= 1 and stays constant during a byte.
module sq_shift #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [7:0]       tx_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             miso_i,
    output logic             sclk_o,
    output logic             mosi_o,
    output logic             done_o,
    output logic [7:0]       rx_o
);
    logic             busy_q, sclk_q, done_q;
    logic [DIV_W-1:0] cnt_q;
    logic [2:0]       bit_q;
    logic [7:0]       sh_q, rx_q;

    // Bit engine: counts half periods, toggles SCLK, samples and shifts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
            rx_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (start_i && !busy_q) begin
                busy_q <= 1'b1;
                cnt_q  <= div_i - 1'b1;
                bit_q  <= '0;
                sh_q   <= tx_i;
            end else if (busy_q) begin
                if (cnt_q == '0) begin
                    cnt_q <= div_i - 1'b1;
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                        rx_q   <= {rx_q[6:0], miso_i};
                    end else begin
                        sclk_q <= 1'b0;
                        if (bit_q == 3'd7) begin
                            busy_q <= 1'b0;
                            done_q <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                            sh_q  <= {sh_q[6:0], 1'b0};
                        end
                    end
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign sclk_o = sclk_q;
    assign mosi_o = busy_q & sh_q[7];
    assign done_o = done_q;
    assign rx_o   = rx_q;

    // SCLK must idle low whenever no byte is in flight.
    assert_sclk_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !sclk_q);
    // A byte ends on a falling SCLK edge.
    assert_byte_ends_falling_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!sclk_q && $past(sclk_q)));
endmodule

// File: rtl/sq_seq.sv
// Module: sq_seq
// Queue sequencer. It walks the entries from the start index to the end index
// and wraps at DEPTH. It drives the chip selects from each command word and
// decides keep or release per entry and at the end of a run. Assumes DEPTH is
// a power of two.
module sq_seq import sq_pkg::*; #(
    parameter int DEPTH = 16,
    parameter int DIV_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [IDX_W-1:0] new_idx_i,
    input  logic [IDX_W-1:0] end_idx_i,
    input  logic [7:0]       cmd_i,
    input  logic             hold_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             shift_done_i,
    output logic [IDX_W-1:0] cur_idx_o,
    output logic             busy_o,
    output logic             shift_start_o,
    output logic             rx_we_o,
    output logic             done_set_o,
    output logic [3:0]       cs_n_o
);
    localparam int TW = DIV_W + 2;

    sq_state_t        state_q;
    logic [IDX_W-1:0] cur_q;
    logic [7:0]       cmd_q;
    logic [TW-1:0]    timer_q;
    logic [3:0]       cs_q;
    logic             last_w, keep_w;
    logic             cmd_unused;

    assign last_w = (cur_q == end_idx_i);
    assign keep_w = cmd_q[CMD_KEEP] && (!last_w || hold_i);
    assign cmd_unused = ^{cmd_q[6:5]};

    // Run control: pointer, chip selects and setup/gap timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cur_q   <= '0;
            cmd_q   <= '0;
            timer_q <= '0;
            cs_q    <= 4'hF;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (start_i) begin
                        cur_q   <= new_idx_i;
                        state_q <= SQ_LOAD;
                    end else if (cs_q != 4'hF && !hold_i) begin
                        cs_q <= 4'hF;
                    end
                end
                SQ_LOAD: begin
                    cmd_q   <= cmd_i;
                    cs_q    <= cmd_i[3:0];
                    timer_q <= (cmd_i[CMD_DLY] ? {1'b0, div_i, 1'b0} : {2'b00, div_i})
                               - TW'(1);
                    state_q <= SQ_SETUP;
                end
                SQ_SETUP: begin
                    if (timer_q == '0) state_q <= SQ_SHIFT;
                    else               timer_q <= timer_q - 1'b1;
                end
                SQ_SHIFT: begin
                    if (shift_done_i) begin
                        if (!keep_w) cs_q <= 4'hF;
                        if (last_w) begin
                            state_q <= SQ_IDLE;
                        end else begin
                            cur_q <= cur_q + 1'b1;
                            if (keep_w) begin
                                state_q <= SQ_LOAD;
                            end else begin
                                timer_q <= {1'b0, div_i, 1'b0} - TW'(1);
                                state_q <= SQ_GAP;
                            end
                        end
                    end
                end
                SQ_GAP: begin
                    if (timer_q == '0) state_q <= SQ_LOAD;
                    else               timer_q <= timer_q - 1'b1;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign cur_idx_o     = cur_q;
    assign busy_o        = (state_q != SQ_IDLE);
    assign shift_start_o = (state_q == SQ_SETUP) && (timer_q == '0);
    assign rx_we_o       = (state_q == SQ_SHIFT) && shift_done_i;
    assign done_set_o    = rx_we_o && last_w;
    assign cs_n_o        = cs_q;

    // A start request while idle always begins a run.
    assert_start_leaves_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_IDLE && start_i) |=> busy_o);
    // Chip selects are released for the whole inter-entry gap.
    assert_gap_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_GAP) |-> (cs_n_o == 4'hF));
    // Chip selects do not move while a byte is shifting.
    assert_cs_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_SHIFT && $past(state_q) == SQ_SHIFT) |-> $stable(cs_n_o));
endmodule

// File: rtl/sq_regs.sv
// Module: sq_regs
// Register file: divider, queue pointers, control, status, hold register,
// and the transmit, receive and command stores. Transmit and receive use two
// word slots per entry: even slots carry data in the transmit store and odd
// slots in the receive store. Assumes DEPTH <= 16 so that regions don't overlap.
module sq_regs import sq_pkg::*; #(
    parameter int DEPTH  = 16,
    parameter int DIV_W  = 8,
    parameter int ADDR_W = 12,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              seq_busy_i,
    input  logic [IDX_W-1:0]  cur_idx_i,
    input  logic              rx_we_i,
    input  logic [7:0]        rx_data_i,
    input  logic              done_set_i,
    output logic              start_o,
    output logic [IDX_W-1:0]  new_idx_o,
    output logic [IDX_W-1:0]  end_idx_o,
    output logic [7:0]        cmd_o,
    output logic [7:0]        tx_o,
    output logic [DIV_W-1:0]  div_o,
    output logic              hold_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] TX_LO  = ADDR_W'(OFF_TXRAM);
    localparam logic [ADDR_W-1:0] TX_HI  = ADDR_W'(OFF_TXRAM + DEPTH * 8);
    localparam logic [ADDR_W-1:0] RX_LO  = ADDR_W'(OFF_RXRAM);
    localparam logic [ADDR_W-1:0] RX_HI  = ADDR_W'(OFF_RXRAM + DEPTH * 8);
    localparam logic [ADDR_W-1:0] CMD_LO = ADDR_W'(OFF_CMDRAM);
    localparam logic [ADDR_W-1:0] CMD_HI = ADDR_W'(OFF_CMDRAM + DEPTH * 4);

    logic [7:0]       tx_mem  [DEPTH];
    logic [7:0]       rx_mem  [DEPTH];
    logic [7:0]       cmd_mem [DEPTH];
    logic [DIV_W-1:0] div_q;
    logic [IDX_W-1:0] new_q, end_q;
    logic             cont_q, start_q, done_q, hold_q;
    logic             busy_any, wr;
    logic             in_tx, in_rx, in_cmd;
    logic [ADDR_W-1:0] off_tx, off_rx, off_cmd;
    logic             wdata_unused;

    assign busy_any = seq_busy_i | start_q;
    assign wr       = bus_en & bus_wr;
    assign in_tx    = (bus_addr >= TX_LO)  && (bus_addr < TX_HI);
    assign in_rx    = (bus_addr >= RX_LO)  && (bus_addr < RX_HI);
    assign in_cmd   = (bus_addr >= CMD_LO) && (bus_addr < CMD_HI);
    assign off_tx   = bus_addr - TX_LO;
    assign off_rx   = bus_addr - RX_LO;
    assign off_cmd  = bus_addr - CMD_LO;
    assign wdata_unused = ^{bus_wdata, off_tx, off_rx, off_cmd};

    // Register and store updates from bus writes and the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q   <= DIV_W'(1);
            new_q   <= '0;
            end_q   <= '0;
            cont_q  <= 1'b0;
            start_q <= 1'b0;
            done_q  <= 1'b0;
            hold_q  <= 1'b0;
            for (int i = 0; i < DEPTH; i++) begin
                tx_mem[i]  <= '0;
                rx_mem[i]  <= '0;
                cmd_mem[i] <= '0;
            end
        end else begin
            start_q <= 1'b0;
            if (wr) begin
                if (bus_addr == ADDR_W'(OFF_DIV))
                    div_q <= (bus_wdata[DIV_W-1:0] == '0) ? DIV_W'(1) : bus_wdata[DIV_W-1:0];
                if (bus_addr == ADDR_W'(OFF_NEWQ)) new_q <= bus_wdata[IDX_W-1:0];
                if (bus_addr == ADDR_W'(OFF_ENDQ)) end_q <= bus_wdata[IDX_W-1:0];
                if (bus_addr == ADDR_W'(OFF_CTRL) && !busy_any) begin
                    cont_q  <= bus_wdata[CTL_CONT];
                    start_q <= bus_wdata[CTL_EN];
                end
                if (bus_addr == ADDR_W'(OFF_STATUS) && !bus_wdata[0]) done_q <= 1'b0;
                if (bus_addr == ADDR_W'(OFF_HOLD)) hold_q <= bus_wdata[0];
                if (in_tx && !off_tx[2]) tx_mem[off_tx[IDX_W+2:3]] <= bus_wdata[7:0];
                if (in_cmd) cmd_mem[off_cmd[IDX_W+1:2]] <= bus_wdata[7:0];
            end
            if (done_set_i) done_q <= 1'b1;
            if (rx_we_i) rx_mem[cur_idx_i] <= rx_data_i;
        end
    end

    // Read multiplexer, combinational from the address.
    always_comb begin
        bus_rdata = '0;
        if (bus_en) begin
            if (bus_addr == ADDR_W'(OFF_DIV))    bus_rdata = 32'(div_q);
            if (bus_addr == ADDR_W'(OFF_NEWQ))   bus_rdata = 32'(new_q);
            if (bus_addr == ADDR_W'(OFF_ENDQ))   bus_rdata = 32'(end_q);
            if (bus_addr == ADDR_W'(OFF_CTRL))   bus_rdata = 32'({cont_q, busy_any, 6'b0});
            if (bus_addr == ADDR_W'(OFF_STATUS)) bus_rdata = 32'(done_q);
            if (bus_addr == ADDR_W'(OFF_CURQ))   bus_rdata = 32'(cur_idx_i);
            if (bus_addr == ADDR_W'(OFF_HOLD))   bus_rdata = 32'(hold_q);
            if (in_tx && !off_tx[2]) bus_rdata = 32'(tx_mem[off_tx[IDX_W+2:3]]);
            if (in_rx && off_rx[2])  bus_rdata = 32'(rx_mem[off_rx[IDX_W+2:3]]);
            if (in_cmd)              bus_rdata = 32'(cmd_mem[off_cmd[IDX_W+1:2]]);
        end
    end

    assign start_o   = start_q;
    assign new_idx_o = new_q;
    assign end_idx_o = end_q;
    assign cmd_o     = cmd_mem[cur_idx_i];
    assign tx_o      = tx_mem[cur_idx_i];
    assign div_o     = div_q;
    assign hold_o    = cont_q | hold_q;
    assign irq_o     = done_q;

    // Completion always raises the interrupt on the following cycle.
    assert_done_raises_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_set_i |=> irq_o);
endmodule

// File: rtl/sq_spi_master.sv
// Module: sq_spi_master (top)
// Queued SPI master. It ties together the register file, the queue sequencer
// and the byte shifter. Assumes a single clock domain and that MISO has
// already been synchronised.
module sq_spi_master #(
    parameter int DEPTH  = 16,
    parameter int DIV_W  = 8,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [3:0]        cs_n,
    output logic              irq
);
    localparam int IDX_W = $clog2(DEPTH);

    logic             start_w, hold_w, busy_w, sh_start_w, sh_done_w;
    logic             rx_we_w, done_set_w;
    logic [IDX_W-1:0] new_w, end_w, cur_w;
    logic [7:0]       cmd_w, tx_w, rx_w;
    logic [DIV_W-1:0] div_w;

    sq_regs #(.DEPTH(DEPTH), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .seq_busy_i(busy_w), .cur_idx_i(cur_w), .rx_we_i(rx_we_w),
        .rx_data_i(rx_w), .done_set_i(done_set_w), .start_o(start_w),
        .new_idx_o(new_w), .end_idx_o(end_w), .cmd_o(cmd_w), .tx_o(tx_w),
        .div_o(div_w), .hold_o(hold_w), .irq_o(irq)
    );

    sq_seq #(.DEPTH(DEPTH), .DIV_W(DIV_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_w), .new_idx_i(new_w),
        .end_idx_i(end_w), .cmd_i(cmd_w), .hold_i(hold_w), .div_i(div_w),
        .shift_done_i(sh_done_w), .cur_idx_o(cur_w), .busy_o(busy_w),
        .shift_start_o(sh_start_w), .rx_we_o(rx_we_w),
        .done_set_o(done_set_w), .cs_n_o(cs_n)
    );

    sq_shift #(.DIV_W(DIV_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .start_i(sh_start_w), .tx_i(tx_w),
        .div_i(div_w), .miso_i(miso), .sclk_o(sclk), .mosi_o(mosi),
        .done_o(sh_done_w), .rx_o(rx_w)
    );
endmodule

// File: tb/sq_spi_master_test.sv
`timescale 1ns/1ps
module sq_spi_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sclk, mosi, miso;
    logic [3:0]  cs_n;
    logic        irq;

    int n_cmp = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    sq_spi_master uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .irq(irq)
    );

    // Scoreboard state: expected {entry, cs pattern, tx byte} per byte.
    logic [15:0] exp_q[$];
    logic [7:0]  tx_m  [16];
    logic [7:0]  cmd_m [16];
    logic [7:0]  exp_rx[16];
    int          slave_idx = 0, mon_bit = 0;
    logic [7:0]  mon_sh = '0;
    logic [7:0]  cur_pat;
    int          frames = 0, hi_cnt = 0, min_gap = 1000, setup_cnt = 0, last_setup = 0;
    bit          setup_meas = 0;
    logic [3:0]  prev_cs = 4'hF;

    assign cur_pat = 8'h3C ^ 8'(slave_idx * 37);
    assign miso = (cs_n != 4'hF) ? cur_pat[3'(7 - mon_bit)] : 1'b0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: captures each byte at SCLK rise and compares with the queue (R2, R6).
    always @(posedge sclk) begin
        mon_sh = {mon_sh[6:0], mosi};
        mon_bit++;
        if (mon_bit == 8) begin
            logic [15:0] it;
            mon_bit = 0;
            if (exp_q.size() == 0) begin
                check("R2", 32'(mon_sh), 32'hFFFF, "unexpected byte");
            end else begin
                it = exp_q.pop_front();
                check("R2", 32'(mon_sh), 32'(it[7:0]), "mosi byte");
                check("R6", 32'(cs_n), 32'(it[11:8]), "cs pattern");
                exp_rx[it[15:12]] = cur_pat;
            end
            slave_idx++;
        end
    end

    // Frame, gap and setup-time tracking, sampled away from the clock edge.
    always @(negedge clk) begin
        if (prev_cs == 4'hF && cs_n != 4'hF) begin
            frames++;
            if (hi_cnt < min_gap) min_gap = hi_cnt;
            setup_meas = 1;
            setup_cnt = 0;
        end
        if (cs_n == 4'hF) hi_cnt++; else hi_cnt = 0;
        if (setup_meas) begin
            setup_cnt++;
            if (sclk) begin last_setup = setup_cnt; setup_meas = 0; end
        end
        prev_cs = cs_n;
    end

    task automatic bus_write(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_wr = 1; bus_addr = 12'(a); bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_wr = 0; bus_addr = 12'(a);
        #1 d = bus_rdata;
        bus_en = 0;
    endtask

    // Driver: fills one entry and records it for the scoreboard.
    task automatic load_entry(int i, logic [7:0] tx, logic [7:0] cmd);
        tx_m[i] = tx; cmd_m[i] = cmd;
        bus_write('h240 + 8 * i, 32'(tx));
        bus_write('h340 + 4 * i, 32'(cmd));
    endtask

    task automatic run_q(int nq, int eq, bit cont);
        logic [31:0] d;
        for (int k = 0; k < 16; k++) begin
            int ix = (nq + k) % 16;
            exp_q.push_back({4'(ix), cmd_m[ix][3:0], tx_m[ix]});
            if (ix == eq) break;
        end
        bus_write('h210, 32'(nq));
        bus_write('h214, 32'(eq));
        bus_write('h218, 32'h40 | (32'(cont) << 7));
        bus_read('h218, d);
        check("R4", 32'(d[6]), 1, "enable while running");
        for (int t = 0; t < 20000 && !irq; t++) @(negedge clk);
        check("R5", 32'(irq), 1, "irq at completion");
        bus_read('h218, d);
        check("R4", 32'(d[6]), 0, "enable self-clears");
        check("R2", 32'(exp_q.size()), 0, "all bytes sent");
    endtask

    task automatic clear_done();
        logic [31:0] d;
        bus_read('h220, d);
        check("R5", d, 1, "status done");
        bus_write('h220, 0);
        bus_read('h220, d);
        check("R5", d, 0, "status cleared");
        check("R5", 32'(irq), 0, "irq cleared");
    endtask

    task automatic check_rx(int i);
        logic [31:0] d;
        bus_read('h2C0 + 8 * i + 4, d);
        check("R3", d, 32'(exp_rx[i]), "rx odd slot");
        bus_read('h2C0 + 8 * i, d);
        check("R3", d, 0, "rx even slot");
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int f0, s0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1", 32'(cs_n), 32'hF, "cs_n");
        check("R1", 32'(sclk), 0, "sclk");
        check("R1", 32'(irq), 0, "irq");
        bus_read('h218, d); check("R1", d, 0, "control");
        bus_read('h220, d); check("R1", d, 0, "status");

        // R2/R3/R6/R7/R10: held frame of four entries
        bus_write('h200, 2);
        load_entry(0, 8'h11, 8'h8E); load_entry(1, 8'h22, 8'h8E);
        load_entry(2, 8'hA7, 8'h8E); load_entry(3, 8'h44, 8'h0E);
        f0 = frames;
        run_q(0, 3, 0);
        check("R7", 32'(frames - f0), 1, "one frame when kept");
        for (int i = 0; i < 4; i++) check_rx(i);
        bus_read('h224, d); check("R10", d, 3, "current pointer");
        check("R7", 32'(cs_n), 32'hF, "released after last");
        clear_done();

        // R7: entries without continue, gap of at least one SCLK period
        bus_write('h200, 3);
        load_entry(4, 8'h5A, 8'h0D); load_entry(5, 8'hC3, 8'h0D); load_entry(6, 8'h01, 8'h0D);
        f0 = frames; min_gap = 1000;
        run_q(4, 6, 0);
        check("R7", 32'(frames - f0), 3, "frame per entry");
        check("R7", 32'(min_gap >= 6), 1, "gap length");
        clear_done();

        // R12: clock-delay bit adds one half period
        bus_write('h200, 2);
        load_entry(7, 8'h96, 8'h07);
        run_q(7, 7, 0); s0 = last_setup; clear_done();
        load_entry(7, 8'h69, 8'h17);
        run_q(7, 7, 0);
        check("R12", 32'(last_setup - s0), 2, "setup extension");
        clear_done();

        // R8: continue-after-run mode keeps the frame across runs
        load_entry(8, 8'hE1, 8'h8B); load_entry(9, 8'h1E, 8'h0B);
        f0 = frames;
        run_q(8, 8, 1);
        check("R8", 32'(cs_n), 32'hB, "held after run");
        clear_done();
        run_q(9, 9, 1);
        check("R8", 32'(frames - f0), 1, "same frame across runs");
        clear_done();
        bus_write('h218, 0);

        // R8: hold register keeps cs, clearing it releases
        bus_write('h380, 1);
        run_q(8, 8, 0);
        check("R8", 32'(cs_n), 32'hB, "held by hold register");
        clear_done();
        bus_write('h380, 0);
        @(negedge clk);
        check("R8", 32'(cs_n), 32'hF, "released when hold cleared");

        // R9: continue on last entry without either hold control
        run_q(8, 8, 0);
        check("R9", 32'(cs_n), 32'hF, "released without hold");
        clear_done();

        // R11: wraparound from 15 to 0
        load_entry(14, 8'h81, 8'h8E); load_entry(15, 8'h42, 8'h8E);
        load_entry(0, 8'h24, 8'h8E);  load_entry(1, 8'h18, 8'h0E);
        run_q(14, 1, 0);
        bus_read('h224, d); check("R11", d, 1, "end pointer after wrap");
        check_rx(14); check_rx(15); check_rx(0); check_rx(1);
        clear_done();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule